// File: doc/BRIEF.md
# Four-Channel DMA Register Interface and Transfer Sequencer

This block is the register interface of a four-channel DMA controller. It sits on an 8-bit I/O bus. Software uses it to program a 16-bit start address and a 16-bit transfer count for each channel. It can also mask or unmask channels, choose the transfer direction, enable automatic reload, raise software requests, and read back status. Each 16-bit register is reached through a single byte offset. A byte pointer, shared by all channels, selects the low or the high half. It flips after every access to an address or count offset, and software can force it back to the low half.

A small sequencer sits behind the registers. In every cycle with no bus access, it picks the lowest-numbered channel that is unmasked and requesting, and gives it a one-cycle acknowledge. On that cycle the sequencer shows the channel's current address and direction, then decrements the current count and advances the current address. The count is stored as length minus one. A transfer made at count zero is the terminal one. It latches a status flag, and it then either masks the channel or reloads the channel from its base registers.

A parameter selects a word-spaced variant. In that variant the register offsets are doubled and the address counts 16-bit words, so the transfer address that leaves the block is the word address shifted left by one.

Top module: `dmac_regif`

## Requirements
- R1: After reset all four channels are masked (mask readback at offset 0x0F returns 0x0F), the status register reads 0x00, the byte pointer selects the low byte, and no acknowledge is raised even with all requests high.
- R2: Channel n's address register sits at offset 2n and its count register at offset 2n+1. Each is written and read as two byte accesses, low byte first, and the byte pointer flips after every such access. A write loads both the base and the current register. A read returns the current value.
- R3: Any write to offset 0x0C returns the byte pointer to the low byte.
- R4: A write to offset 0x0A changes only the channel named by data bits [1:0]. Data bit 2 = 1 masks that channel and bit 2 = 0 unmasks it.
- R5: A write to offset 0x0E unmasks all channels. A write to offset 0x0F sets mask bit n from data bit n. A read of 0x0F returns the four mask bits in [3:0], with [7:4] = 0.
- R6: A write to offset 0x0B sets the mode of the channel named by bits [1:0]. Bits [3:2] are the direction (01 = into memory, 10 = out of memory), shown on `xfer_dir` during that channel's transfers. Bit 4 enables automatic reload.
- R7: In a cycle with no bus access and with command bit 2 clear, the lowest-numbered unmasked channel whose hardware or software request is set gets a one-cycle one-hot acknowledge. `xfer_addr` shows its current address. The transfer then decrements the current count and increments the current address. A write to offset 0x08 with bit 2 set stops all transfers.
- R8: A transfer made at count 0 raises `xfer_tc`, wraps the count to 0xFFFF and sets status bit n. It then masks the channel, or, with automatic reload, copies the base address and count back into the current registers and leaves the channel unmasked.
- R9: A read of offset 0x08 returns the terminal-count flags in [3:0] and the live request of each channel (hardware or software) in [7:4]. The read clears the flags.
- R10: A write to offset 0x09 sets (bit 2 = 1) or clears the software request of the channel named by bits [1:0]. A terminal count on that channel clears its software request.
- R11: A write to offset 0x0D masks every channel and clears the byte pointer, the status flags and the software requests. The address and count registers keep their values.
- R12: With WORD_MODE = 1, every offset above is doubled, accesses at odd offsets are ignored, and `xfer_addr` is twice the current word address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 5 | Register offset |
| io_wr | input | 1 | Write strobe, one cycle per byte |
| io_rd | input | 1 | Read strobe, one cycle per byte; read side effects occur at the clock edge that ends the strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid while io_rd is high |
| dreq | input | 4 | Hardware request per channel |
| dack | output | 4 | One-hot acknowledge of the channel being served |
| xfer_addr | output | 16 + WORD_MODE | Byte address of the current transfer |
| xfer_dir | output | 2 | Direction field of the served channel |
| xfer_tc | output | 1 | High on the terminal transfer of the served channel |

## Verification
The checker assumes that `io_wr` and `io_rd` are never high together and that each strobe lasts one cycle per byte access. The decoder and the stall rule depend on both assumptions. The bench drives every access through tasks that pulse exactly one strobe for one cycle, and it places these accesses back to back so that no idle cycle lets a channel with a pending request transfer in the middle of a programming sequence. Requests are changed only on falling edges, and the ordering checks are made before the rising edge that commits the transfer.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    localparam int NCH = 4;
    localparam int CHW = 2;
    localparam int DW  = 8;
    localparam int AW  = 16;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_ADDR,
        SEL_CNT,
        SEL_CMDST,
        SEL_REQ,
        SEL_MASK1,
        SEL_MODE,
        SEL_CLRFF,
        SEL_TMPRST,
        SEL_CLRMASK,
        SEL_MASKALL
    } sel_e;

    typedef struct packed {
        logic       autoinit;
        logic [1:0] dir;
    } mode_t;

    function automatic sel_e map_offset(input logic [3:0] idx);
        sel_e s;
        if (!idx[3]) begin
            s = idx[0] ? SEL_CNT : SEL_ADDR;
        end else begin
            case (idx[2:0])
                3'd0:    s = SEL_CMDST;
                3'd1:    s = SEL_REQ;
                3'd2:    s = SEL_MASK1;
                3'd3:    s = SEL_MODE;
                3'd4:    s = SEL_CLRFF;
                3'd5:    s = SEL_TMPRST;
                3'd6:    s = SEL_CLRMASK;
                default: s = SEL_MASKALL;
            endcase
        end
        return s;
    endfunction

    function automatic mode_t unpack_mode(input logic [DW-1:0] d);
        mode_t m;
        m.autoinit = d[4];
        m.dir      = d[3:2];
        return m;
    endfunction

endpackage

// File: rtl/dmac_decode.sv
module dmac_decode
    import dmac_pkg::*;
#(
    parameter bit WORD_MODE = 1'b0
) (
    input  logic [4:0]    io_addr,
    input  logic [DW-1:0] io_wdata,
    output sel_e          sel,
    output logic [CHW-1:0] chan
);

    logic [3:0] idx;
    logic       hit;

    generate
        if (WORD_MODE) begin : g_word
            assign idx = io_addr[4:1];
            assign hit = !io_addr[0];
        end else begin : g_byte
            assign idx = io_addr[3:0];
            assign hit = !io_addr[4];
        end
    endgenerate

    always_comb begin
        sel = hit ? map_offset(idx) : SEL_NONE;
        if (sel == SEL_ADDR || sel == SEL_CNT) begin
            chan = idx[2:1];
        end else begin
            chan = io_wdata[CHW-1:0];
        end
    end

endmodule

// File: rtl/dmac_arbiter.sv
module dmac_arbiter #(
    parameter int N = 4
) (
    input  logic         en,
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);

    always_comb begin
        grant = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (en && req[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/dmac_channel.sv
module dmac_channel
    import dmac_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          mrst,
    input  logic          wr_addr,
    input  logic          wr_cnt,
    input  logic          hi_sel,
    input  logic [DW-1:0] wdata,
    input  logic          mask_we,
    input  logic          mask_val,
    input  logic          mode_we,
    input  mode_t         mode_in,
    input  logic          sreq_we,
    input  logic          sreq_val,
    input  logic          tc_clr,
    input  logic          grant,
    output logic [AW-1:0] cur_addr,
    output logic [AW-1:0] cur_cnt,
    output logic          masked,
    output logic          tc,
    output logic          sreq,
    output mode_t         mode
);

    logic [AW-1:0] base_addr;
    logic [AW-1:0] base_cnt;
    logic          last_xfer;

    assign last_xfer = (cur_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_addr <= '0;
            base_cnt  <= '0;
            cur_addr  <= '0;
            cur_cnt   <= '0;
            masked    <= 1'b1;
            tc        <= 1'b0;
            sreq      <= 1'b0;
            mode      <= '0;
        end else if (mrst) begin
            masked <= 1'b1;
            tc     <= 1'b0;
            sreq   <= 1'b0;
        end else begin
            if (wr_addr) begin
                if (hi_sel) begin
                    base_addr[AW-1:DW] <= wdata;
                    cur_addr[AW-1:DW]  <= wdata;
                end else begin
                    base_addr[DW-1:0] <= wdata;
                    cur_addr[DW-1:0]  <= wdata;
                end
            end
            if (wr_cnt) begin
                if (hi_sel) begin
                    base_cnt[AW-1:DW] <= wdata;
                    cur_cnt[AW-1:DW]  <= wdata;
                end else begin
                    base_cnt[DW-1:0] <= wdata;
                    cur_cnt[DW-1:0]  <= wdata;
                end
            end
            if (mask_we) masked <= mask_val;
            if (mode_we) mode   <= mode_in;
            if (sreq_we) sreq   <= sreq_val;
            if (tc_clr)  tc     <= 1'b0;
            if (grant) begin
                if (last_xfer) begin
                    tc   <= 1'b1;
                    sreq <= 1'b0;
                    if (mode.autoinit) begin
                        cur_addr <= base_addr;
                        cur_cnt  <= base_cnt;
                    end else begin
                        cur_addr <= cur_addr + 1'b1;
                        cur_cnt  <= cur_cnt - 1'b1;
                        masked   <= 1'b1;
                    end
                end else begin
                    cur_addr <= cur_addr + 1'b1;
                    cur_cnt  <= cur_cnt - 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/dmac_regif.sv
module dmac_regif
    import dmac_pkg::*;
#(
    parameter bit WORD_MODE = 1'b0,
    localparam int XAW = AW + (WORD_MODE ? 1 : 0)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [4:0]     io_addr,
    input  logic           io_wr,
    input  logic           io_rd,
    input  logic [DW-1:0]  io_wdata,
    output logic [DW-1:0]  io_rdata,
    input  logic [NCH-1:0] dreq,
    output logic [NCH-1:0] dack,
    output logic [XAW-1:0] xfer_addr,
    output logic [1:0]     xfer_dir,
    output logic           xfer_tc
);

    sel_e           sel;
    logic [CHW-1:0] chan;
    logic           ff_q;
    logic           halt_q;
    logic           mrst;
    logic           tc_clr;
    logic           bus_busy;
    logic [NCH-1:0] mask_q;
    logic [NCH-1:0] tc_q;
    logic [NCH-1:0] sreq_q;
    logic [NCH-1:0] eligible;
    logic [NCH-1:0] live_req;
    logic [AW-1:0]  cur_addr [NCH];
    logic [AW-1:0]  cur_cnt  [NCH];
    mode_t          mode_q   [NCH];
    logic [AW-1:0]  sel_addr;

    dmac_decode #(.WORD_MODE(WORD_MODE)) u_dec (
        .io_addr  (io_addr),
        .io_wdata (io_wdata),
        .sel      (sel),
        .chan     (chan)
    );

    assign bus_busy = io_wr || io_rd;
    assign mrst     = io_wr && (sel == SEL_TMPRST);
    assign tc_clr   = io_rd && (sel == SEL_CMDST);

    always_ff @(posedge clk) begin
        if (rst) begin
            ff_q   <= 1'b0;
            halt_q <= 1'b0;
        end else if (mrst) begin
            ff_q   <= 1'b0;
            halt_q <= 1'b0;
        end else begin
            if (io_wr && sel == SEL_CLRFF) begin
                ff_q <= 1'b0;
            end else if (bus_busy && (sel == SEL_ADDR || sel == SEL_CNT)) begin
                ff_q <= !ff_q;
            end
            if (io_wr && sel == SEL_CMDST) halt_q <= io_wdata[2];
        end
    end

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            logic is_me;
            logic m_we;
            logic m_val;
            assign is_me = (chan == CHW'(i));
            assign m_we  = io_wr && ((sel == SEL_MASK1 && is_me) ||
                                     sel == SEL_CLRMASK || sel == SEL_MASKALL);
            assign m_val = (sel == SEL_MASK1)   ? io_wdata[2] :
                           (sel == SEL_MASKALL) ? io_wdata[i] : 1'b0;

            dmac_channel u_ch (
                .clk      (clk),
                .rst      (rst),
                .mrst     (mrst),
                .wr_addr  (io_wr && sel == SEL_ADDR && is_me),
                .wr_cnt   (io_wr && sel == SEL_CNT && is_me),
                .hi_sel   (ff_q),
                .wdata    (io_wdata),
                .mask_we  (m_we),
                .mask_val (m_val),
                .mode_we  (io_wr && sel == SEL_MODE && is_me),
                .mode_in  (unpack_mode(io_wdata)),
                .sreq_we  (io_wr && sel == SEL_REQ && is_me),
                .sreq_val (io_wdata[2]),
                .tc_clr   (tc_clr),
                .grant    (dack[i]),
                .cur_addr (cur_addr[i]),
                .cur_cnt  (cur_cnt[i]),
                .masked   (mask_q[i]),
                .tc       (tc_q[i]),
                .sreq     (sreq_q[i]),
                .mode     (mode_q[i])
            );

            assign live_req[i] = dreq[i] || sreq_q[i];
            assign eligible[i] = live_req[i] && !mask_q[i];
        end
    endgenerate

    dmac_arbiter #(.N(NCH)) u_arb (
        .en    (!halt_q && !bus_busy),
        .req   (eligible),
        .grant (dack)
    );

    always_comb begin
        sel_addr = '0;
        xfer_dir = '0;
        xfer_tc  = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            if (dack[i]) begin
                sel_addr = cur_addr[i];
                xfer_dir = mode_q[i].dir;
                xfer_tc  = (cur_cnt[i] == '0);
            end
        end
    end

    generate
        if (WORD_MODE) begin : g_waddr
            assign xfer_addr = {sel_addr, 1'b0};
        end else begin : g_baddr
            assign xfer_addr = sel_addr;
        end
    endgenerate

    always_comb begin
        io_rdata = '0;
        if (io_rd) begin
            case (sel)
                SEL_ADDR:    io_rdata = ff_q ? cur_addr[chan][AW-1:DW] : cur_addr[chan][DW-1:0];
                SEL_CNT:     io_rdata = ff_q ? cur_cnt[chan][AW-1:DW]  : cur_cnt[chan][DW-1:0];
                SEL_CMDST:   io_rdata = {live_req, tc_q};
                SEL_MASKALL: io_rdata = {{(DW-NCH){1'b0}}, mask_q};
                default:     io_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/dmac_regif_chk.sv
module dmac_regif_chk
    import dmac_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           io_wr,
    input logic           io_rd,
    input sel_e           sel,
    input logic [NCH-1:0] dreq,
    input logic [NCH-1:0] dack,
    input logic [NCH-1:0] mask_q,
    input logic [NCH-1:0] tc_q,
    input logic           ff_q
);

    // R7
    dack_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dack));

    // R7
    bus_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (io_wr || io_rd) |-> (dack == '0));

    // R7
    prio_chk: assert property (@(posedge clk) disable iff (rst)
        dack[1] |-> !(dreq[0] && !mask_q[0]));

    // R8
    masked_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (dack & mask_q) == '0);

    // R3
    clr_ptr_chk: assert property (@(posedge clk) disable iff (rst)
        (io_wr && sel == SEL_CLRFF) |=> !ff_q);

    // R9
    status_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (io_rd && sel == SEL_CMDST) |=> (tc_q == '0));

    // R11
    master_rst_chk: assert property (@(posedge clk) disable iff (rst)
        (io_wr && sel == SEL_TMPRST) |=> (mask_q == '1 && !ff_q && tc_q == '0));

endmodule

bind dmac_regif dmac_regif_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .io_wr  (io_wr),
    .io_rd  (io_rd),
    .sel    (sel),
    .dreq   (dreq),
    .dack   (dack),
    .mask_q (mask_q),
    .tc_q   (tc_q),
    .ff_q   (ff_q)
);

// File: tb/dmac_regif_tb.sv
module dmac_regif_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] io_addr = '0;
    logic       io_wr = 1'b0;
    logic       io_rd = 1'b0;
    logic [7:0] io_wdata = '0;
    logic [3:0] dreq = '0;
    logic       w_odd = 1'b0;

    logic [7:0]  rdata, w_rdata;
    logic [3:0]  dack, w_dack;
    logic [15:0] xaddr;
    logic [16:0] w_xaddr;
    logic [1:0]  xdir, w_xdir;
    logic        xtc, w_xtc;
    logic [4:0]  w_addr;

    int n_tests = 0;
    int n_fail  = 0;
    logic [3:0] rd_dack;

    assign w_addr = {io_addr[3:0], w_odd};

    always #10 clk = ~clk;

    dmac_regif #(.WORD_MODE(1'b0)) dut_i (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(rdata), .dreq(dreq), .dack(dack),
        .xfer_addr(xaddr), .xfer_dir(xdir), .xfer_tc(xtc)
    );

    dmac_regif #(.WORD_MODE(1'b1)) dut_w (
        .clk(clk), .rst(rst), .io_addr(w_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(w_rdata), .dreq(dreq), .dack(w_dack),
        .xfer_addr(w_xaddr), .xfer_dir(w_xdir), .xfer_tc(w_xtc)
    );

    typedef struct packed {
        logic       rd;
        logic [4:0] addr;
        logic [7:0] data;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 5'h0C, 8'h00, 4'd3},  // R3 pointer to low
        '{1'b0, 5'h02, 8'h34, 4'd2},  // R2 ch1 address low
        '{1'b0, 5'h02, 8'h12, 4'd2},  // R2 ch1 address high
        '{1'b0, 5'h03, 8'h02, 4'd2},  // R2 ch1 count low
        '{1'b0, 5'h03, 8'h00, 4'd2},  // R2 ch1 count high
        '{1'b1, 5'h02, 8'h34, 4'd2},  // R2
        '{1'b1, 5'h02, 8'h12, 4'd2},  // R2
        '{1'b1, 5'h03, 8'h02, 4'd2},  // R2 pointer now high
        '{1'b0, 5'h0C, 8'h00, 4'd3},  // R3
        '{1'b1, 5'h03, 8'h02, 4'd3},  // R3 low byte again
        '{1'b1, 5'h03, 8'h00, 4'd2},  // R2
        '{1'b1, 5'h0F, 8'h0F, 4'd1},  // R1 masks after reset
        '{1'b1, 5'h08, 8'h00, 4'd1},  // R1 status after reset
        '{1'b0, 5'h0B, 8'h49, 4'd6},  // R6 ch1 out of memory
        '{1'b0, 5'h0A, 8'h01, 4'd4},  // R4 unmask ch1
        '{1'b1, 5'h0F, 8'h0D, 4'd4},  // R4
        '{1'b0, 5'h0F, 8'h05, 4'd5},  // R5
        '{1'b1, 5'h0F, 8'h05, 4'd5},  // R5
        '{1'b0, 5'h0E, 8'h00, 4'd5},  // R5
        '{1'b1, 5'h0F, 8'h00, 4'd5},  // R5
        '{1'b0, 5'h0F, 8'h0F, 4'd5},  // R5
        '{1'b1, 5'h0F, 8'h0F, 4'd5},  // R5
        '{1'b0, 5'h0A, 8'h01, 4'd4}   // R4 unmask ch1 again
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic io_write(input logic [4:0] a, input logic [7:0] d);
        io_addr  = a;
        io_wdata = d;
        io_wr    = 1'b1;
        @(negedge clk);
        io_wr    = 1'b0;
    endtask

    task automatic io_read(input logic [4:0] a, input logic [7:0] exp, input string req);
        io_addr = a;
        io_rd   = 1'b1;
        #5;
        rd_dack = dack;
        check(rdata == exp, req, rdata, exp);
        check(w_rdata == exp, {req, " R12 word"}, w_rdata, exp);
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic prog16(input logic [4:0] a, input logic [15:0] v);
        io_write(5'h0C, 8'h00);
        io_write(a, v[7:0]);
        io_write(a, v[15:8]);
    endtask

    initial begin : watchdog
        #(20 * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=0x1 expected=0x0");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 masked after reset: no acknowledge although all request
        dreq = 4'hF;
        #5;
        check(dack == 4'h0, "R1", dack, 4'h0);
        @(negedge clk);
        dreq = 4'h0;

        for (int k = 0; k < NV; k++) begin
            if (VEC[k].rd) io_read(VEC[k].addr, VEC[k].data, $sformatf("R%0d vec %0d", VEC[k].req, k));
            else           io_write(VEC[k].addr, VEC[k].data);
        end

        // R7 R8 R6 R12: ch1 three transfers, last one terminal
        dreq = 4'b0010;
        for (int k = 0; k < 3; k++) begin
            #5;
            check(dack == 4'b0010, "R7 ch1 ack", dack, 4'b0010);
            check(xaddr == 16'h1234 + 16'(k), "R7 ch1 addr", xaddr, 16'h1234 + 16'(k));
            check(xdir == 2'b10, "R6 dir", xdir, 2'b10);
            check(xtc == (k == 2), "R8 tc", xtc, (k == 2));
            check(w_xaddr == 17'(2 * (16'h1234 + k)), "R12 word addr", w_xaddr, 2 * (16'h1234 + k));
            @(negedge clk);
        end
        #5;
        check(dack == 4'b0000, "R8 masked after tc", dack, 4'b0000);
        @(negedge clk);
        io_read(5'h08, 8'h22, "R9 status");
        io_read(5'h08, 8'h20, "R9 cleared");
        dreq = 4'b0000;
        io_write(5'h0C, 8'h00);
        io_read(5'h03, 8'hFF, "R8 wrap low");
        io_read(5'h03, 8'hFF, "R8 wrap high");

        // R7 priority ch0 over ch1
        prog16(5'h00, 16'h0100);
        prog16(5'h01, 16'h0005);
        io_write(5'h0A, 8'h00);
        io_write(5'h0A, 8'h01);
        dreq = 4'b0011;
        #5;
        check(dack == 4'b0001, "R7 priority", dack, 4'b0001);
        check(xaddr == 16'h0100, "R7 priority addr", xaddr, 16'h0100);
        @(negedge clk);

        // R7 stall during bus access and command halt
        dreq = 4'b0001;
        io_read(5'h08, 8'h10, "R9 live request");
        check(rd_dack == 4'b0000, "R7 bus stall", rd_dack, 4'b0000);
        #5;
        check(dack == 4'b0001, "R7 resume", dack, 4'b0001);
        @(negedge clk);
        io_write(5'h08, 8'h04);
        #5;
        check(dack == 4'b0000, "R7 halt", dack, 4'b0000);
        @(negedge clk);
        io_write(5'h08, 8'h00);
        #5;
        check(dack == 4'b0001, "R7 unhalt", dack, 4'b0001);
        @(negedge clk);
        dreq = 4'b0000;

        // R8 automatic reload on ch2, direction into memory
        prog16(5'h04, 16'h0040);
        prog16(5'h05, 16'h0001);
        io_write(5'h0B, 8'h56);
        io_write(5'h0A, 8'h02);
        dreq = 4'b0100;
        for (int k = 0; k < 3; k++) begin
            #5;
            check(dack == 4'b0100, "R8 reload ack", dack, 4'b0100);
            check(xaddr == ((k == 1) ? 16'h0041 : 16'h0040), "R8 reload addr", xaddr,
                  (k == 1) ? 16'h0041 : 16'h0040);
            check(xdir == 2'b01, "R6 dir in", xdir, 2'b01);
            check(xtc == (k == 1), "R8 reload tc", xtc, (k == 1));
            @(negedge clk);
        end
        dreq = 4'b0000;
        io_read(5'h08, 8'h04, "R8 status bit2");

        // R10 software request on ch3
        prog16(5'h06, 16'h0200);
        prog16(5'h07, 16'h0000);
        io_write(5'h0B, 8'h4B);
        io_write(5'h0A, 8'h03);
        io_write(5'h09, 8'h07);
        #5;
        check(dack == 4'b1000, "R10 soft ack", dack, 4'b1000);
        check(xtc == 1'b1, "R10 soft tc", xtc, 1'b1);
        @(negedge clk);
        #5;
        check(dack == 4'b0000, "R10 request dropped", dack, 4'b0000);
        @(negedge clk);
        io_read(5'h08, 8'h08, "R10 status");

        // R11 master reset
        io_read(5'h06, 8'h01, "R11 pre low");
        io_write(5'h09, 8'h05);
        io_write(5'h0D, 8'h00);
        io_read(5'h0F, 8'h0F, "R11 masks");
        io_read(5'h08, 8'h00, "R11 status");
        io_read(5'h06, 8'h01, "R11 addr low kept");
        io_read(5'h06, 8'h02, "R11 addr high kept");

        // R12 odd offset ignored in word mode; R5 clear-all in byte mode
        w_odd = 1'b1;
        io_write(5'h0E, 8'h00);
        w_odd = 1'b0;
        dreq = 4'b0001;
        #5;
        check(dack == 4'b0001, "R5 clear all", dack, 4'b0001);
        check(w_dack == 4'b0000, "R12 odd ignored", w_dack, 4'b0000);
        @(negedge clk);
        dreq = 4'b0000;

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule